// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Hazard Control

This block is the combinational decision logic that keeps a five-stage in-order integer pipeline (fetch, decode, ALU, memory, write-back) correct without software-inserted nops. Each cycle it inspects the register numbers and control flags held in the stage registers and decides three things. First, from which later stage each ALU operand should be taken. Second, whether the front of the pipeline must freeze for one cycle. Third, which younger instructions must be turned into nops.

An ALU result still in flight is routed back to a dependent instruction through the operand multiplexors. A load followed at once by a consumer of its destination costs one frozen cycle: the program counter and the decode register hold, a bubble enters the ALU stage, and the loaded value is then taken from the write-back stage. A jump seen in decode discards the one instruction fetched behind it. A branch found taken in the ALU stage discards both younger instructions. The register file, ALU and memories sit outside this block.

Top module: `fwd_hazard_unit`

## Requirements
- R1: Operand select codes are 2'b00 register file, 2'b01 write-back stage value, 2'b10 memory-stage ALU result; code 2'b11 never appears. When the memory-stage instruction writes a nonzero register equal to the ALU-stage source, that source selects 2'b10 (independently for operand A via ex_rs/fwd_a and operand B via ex_rt/fwd_b).
- R2: When the write-back-stage instruction writes a nonzero register equal to an ALU-stage source and the memory stage does not match it, that source selects 2'b01.
- R3: When both the memory stage and the write-back stage write the same register that an ALU-stage source reads, the memory stage (2'b10) wins.
- R4: A destination of register 0, or a cleared write enable, never causes forwarding and never causes a stall.
- R5: When a load in the ALU stage writes a nonzero register read by the decode-stage instruction (either source), stall and bubble_idex are 1 for that cycle; a matching non-load causes no stall.
- R6: One cycle after a load-use stall, with the load now in write-back and the consumer in the ALU stage, the consumer's operand selects 2'b01.
- R7: A jump in decode with no stall and no taken branch raises flush_ifid only; bubble_idex and stall stay 0.
- R8: A taken branch in the ALU stage raises flush_ifid and bubble_idex and forces stall to 0, even when a load-use hazard is present at the same time.
- R9: A jump in decode during a load-use stall does not raise flush_ifid; the jump is held in decode by the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | 5 | First source register of the decode-stage instruction |
| id_rt | input | 5 | Second source register of the decode-stage instruction |
| ex_rs | input | 5 | First source register of the ALU-stage instruction |
| ex_rt | input | 5 | Second source register of the ALU-stage instruction |
| ex_rd | input | 5 | Destination register of the ALU-stage instruction |
| ex_we | input | 1 | ALU-stage instruction writes a register |
| ex_load | input | 1 | ALU-stage instruction is a load |
| mem_rd | input | 5 | Destination register of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | 5 | Destination register of the write-back-stage instruction |
| wb_we | input | 1 | Write-back-stage instruction writes a register |
| id_jump | input | 1 | Decode-stage instruction is an unconditional jump |
| ex_br_taken | input | 1 | ALU-stage branch resolved as taken |
| fwd_a | output | 2 | Operand A source select |
| fwd_b | output | 2 | Operand B source select |
| stall | output | 1 | Hold the program counter and the decode register |
| bubble_idex | output | 1 | Clear the control bits entering the ALU stage |
| flush_ifid | output | 1 | Replace the decode register content with a nop |

## Verification
Two of the block's functions can meet in one cycle: a load-use stall and a control-flow squash, either a taken branch in the ALU stage or a jump in decode. The bench provokes both pairings by presenting a load whose destination matches a decode source together with a taken branch, and again together with a decode jump. In the branch case the stall must vanish while both flush and bubble are raised. In the jump case the stall must win and the decode register must not be flushed. Forwarding from both later stages to the same register is also presented at once, to judge the select priority.

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic [REG_W-1:0] ex_rs,
  input  logic [REG_W-1:0] ex_rt,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_we,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_we,
  input  logic             id_jump,
  input  logic             ex_br_taken,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             stall,
  output logic             bubble_idex,
  output logic             flush_ifid
);

  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;
  localparam logic [REG_W-1:0] ZERO = '0;

  logic mem_live, wb_live, load_live, load_use;

  assign mem_live  = mem_we && (mem_rd != ZERO);
  assign wb_live   = wb_we  && (wb_rd  != ZERO);
  assign load_live = ex_load && ex_we && (ex_rd != ZERO);
  assign load_use  = load_live && ((ex_rd == id_rs) || (ex_rd == id_rt));

  function automatic logic [1:0] pick(input logic [REG_W-1:0] src,
                                      input logic m_ok, input logic [REG_W-1:0] m_rd,
                                      input logic w_ok, input logic [REG_W-1:0] w_rd);
    if (m_ok && m_rd == src)      return SEL_MEM;
    else if (w_ok && w_rd == src) return SEL_WB;
    else                          return SEL_RF;
  endfunction

  assign fwd_a = pick(ex_rs, mem_live, mem_rd, wb_live, wb_rd);
  assign fwd_b = pick(ex_rt, mem_live, mem_rd, wb_live, wb_rd);

  assign stall       = load_use && !ex_br_taken;
  assign bubble_idex = stall || ex_br_taken;
  assign flush_ifid  = ex_br_taken || (id_jump && !stall);

  always_comb begin
    assert_sel_code_R1: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
    assert_no_zero_fwd_R4: assert (!((fwd_a != SEL_RF && ex_rs == ZERO) ||
                                     (fwd_b != SEL_RF && ex_rt == ZERO)));
    assert_stall_bubble_R5: assert (!stall || bubble_idex);
    assert_branch_wins_R8: assert (!ex_br_taken || (!stall && flush_ifid && bubble_idex));
    assert_jump_held_R9: assert (!(stall && flush_ifid));
  end

endmodule

// File: tb/fwd_hazard_unit_tb.sv
module fwd_hazard_unit_tb;
  logic clk = 0;
  always #4 clk = ~clk;

  logic [4:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
  logic ex_we, ex_load, mem_we, wb_we, id_jump, ex_br_taken;
  logic [1:0] fwd_a, fwd_b;
  logic stall, bubble_idex, flush_ifid;
  int checks = 0, errors = 0;

  fwd_hazard_unit u_dut (
    .id_rs(id_rs), .id_rt(id_rt), .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rd(ex_rd),
    .ex_we(ex_we), .ex_load(ex_load), .mem_rd(mem_rd), .mem_we(mem_we),
    .wb_rd(wb_rd), .wb_we(wb_we), .id_jump(id_jump), .ex_br_taken(ex_br_taken),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .bubble_idex(bubble_idex),
    .flush_ifid(flush_ifid));

  task automatic idle();
    id_rs = 0; id_rt = 0; ex_rs = 0; ex_rt = 0; ex_rd = 0; mem_rd = 0; wb_rd = 0;
    ex_we = 0; ex_load = 0; mem_we = 0; wb_we = 0; id_jump = 0; ex_br_taken = 0;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic outs(input string req, input int a, input int b, input int s, input int bub, input int fl);
    check({req, " fwd_a"}, fwd_a, a);
    check({req, " fwd_b"}, fwd_b, b);
    check({req, " stall"}, stall, s);
    check({req, " bubble"}, bubble_idex, bub);
    check({req, " flush"}, flush_ifid, fl);
  endtask

  task automatic t_idle();
    idle(); id_rs = 3; id_rt = 4; ex_rs = 5; ex_rt = 6; settle();
    outs("R1 idle", 0, 0, 0, 0, 0);
  endtask

  task automatic t_mem_fwd();
    idle(); ex_rs = 8; ex_rt = 9; mem_rd = 8; mem_we = 1; settle();
    outs("R1 mem to A", 2, 0, 0, 0, 0);
    mem_rd = 9; settle();
    outs("R1 mem to B", 0, 2, 0, 0, 0);
  endtask

  task automatic t_wb_fwd();
    idle(); ex_rs = 12; ex_rt = 12; wb_rd = 12; wb_we = 1; mem_rd = 13; mem_we = 1; settle();
    outs("R2 wb to both", 1, 1, 0, 0, 0);
  endtask

  task automatic t_priority();
    idle(); ex_rs = 7; ex_rt = 7; mem_rd = 7; mem_we = 1; wb_rd = 7; wb_we = 1; settle();
    outs("R3 mem over wb", 2, 2, 0, 0, 0);
  endtask

  task automatic t_zero();
    idle(); mem_rd = 0; mem_we = 1; wb_rd = 0; wb_we = 1;
    ex_load = 1; ex_we = 1; ex_rd = 0; settle();
    outs("R4 reg0", 0, 0, 0, 0, 0);
    idle(); ex_rs = 10; mem_rd = 10; mem_we = 0; wb_rd = 10; wb_we = 0; settle();
    outs("R4 we low", 0, 0, 0, 0, 0);
    idle(); id_rs = 11; ex_rd = 11; ex_load = 1; ex_we = 0; settle();
    outs("R4 load no we", 0, 0, 0, 0, 0);
  endtask

  task automatic t_load_use();
    idle(); id_rs = 2; id_rt = 15; ex_rd = 15; ex_we = 1; ex_load = 1; settle();
    outs("R5 load-use rt", 0, 0, 1, 1, 0);
    ex_load = 0; settle();
    outs("R5 non-load no stall", 0, 0, 0, 0, 0);
    idle(); ex_rs = 15; wb_rd = 15; wb_we = 1; settle();
    outs("R6 after stall", 1, 0, 0, 0, 0);
  endtask

  task automatic t_jump();
    idle(); id_jump = 1; settle();
    outs("R7 jump", 0, 0, 0, 0, 1);
    idle(); settle();
    outs("R7 one cycle", 0, 0, 0, 0, 0);
  endtask

  task automatic t_branch_vs_stall();
    idle(); id_rs = 20; ex_rd = 20; ex_we = 1; ex_load = 1; ex_br_taken = 1; settle();
    outs("R8 branch over stall", 0, 0, 0, 1, 1);
  endtask

  task automatic t_jump_vs_stall();
    idle(); id_rs = 21; ex_rd = 21; ex_we = 1; ex_load = 1; id_jump = 1; settle();
    outs("R9 jump held", 0, 0, 1, 1, 0);
  endtask

  initial begin
    fork
      begin
        repeat (2000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected done");
      end
      begin
        t_idle(); t_mem_fwd(); t_wb_fwd(); t_priority(); t_zero();
        t_load_use(); t_jump(); t_branch_vs_stall(); t_jump_vs_stall();
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule